// File: doc/BRIEF.md
# Serial Quad RAM Command Front-End

This block is the device-side protocol engine of a serial RAM. It sits behind a four-pin data bus that can work as classic single-bit SPI (data in on lane 0, data out on lane 1) or as a four-lane quad bus. The engine runs entirely on the serial clock, tracks whether the bus is in SPI or quad mode, decodes each command byte, shifts in a 24-bit address, counts the wait cycles the command needs and then streams bytes into or out of a small internal byte array.

The mode-switch commands, the two-step reset and the ID read are handled here. Mode changes and the reset are held back until chip select is deasserted, and chip select going high always ends the current access and returns the engine to its command-receive state. The array has a parameterised depth. The low address bits index it, so any burst wraps around the array.

Top module: `sqram_frontend`

## Requirements
- R1: After `rst_ni` is released, the engine is in SPI mode and `sio_oe_o` is 0.
- R2: Command 0x35 switches the engine to quad mode, and command 0xF5 switches it back to SPI mode. Each switch takes effect when chip select rises. 0x35 is ignored in quad mode and 0xF5 is ignored in SPI mode.
- R3: In SPI mode, commands 0x03 (read, 0 wait cycles), 0x0B (read, 8 wait cycles) and 0x02 (write) take the command, address and data one bit per clock, MSB first. Input is on `sio_i[0]`. Read data comes out on `sio_o[1]` with `sio_oe_o` = 4'b0010.
- R4: In SPI mode, 0xEB (read, 6 wait cycles) and 0x38 (write) take the command on one lane. The address and data use four lanes, with the upper nibble first and `sio_oe_o` = 4'hF while reading.
- R5: In quad mode, the command, address and data all use four lanes, upper nibble first. 0x0B reads after 4 wait cycles, 0xEB reads after 6 wait cycles, and 0x02 and 0x38 are both writes.
- R6: In quad mode, 0x03 and 0x9F are rejected. No lane is driven until chip select rises.
- R7: 0x99 resets the engine to SPI mode only when the command directly before it was 0x66. Any other command after 0x66 cancels the armed state.
- R8: In SPI mode, 0x9F takes a 24-bit address that is ignored and then, with no wait cycles, returns the byte `ID_BYTE` (default 8'h5D) repeatedly on `sio_o[1]`.
- R9: The address is 24 bits sent MSB first, and bit 23 is ignored. The array index is the address modulo `DEPTH`. A burst increments the address by one per byte and continues across any page or array boundary.
- R10: An unknown command byte is ignored. No lane is driven and no byte is written until chip select rises.
- R11: Read data changes only after a falling `sclk_i` edge and holds through the following rising edge. `sio_oe_o` is 0 whenever `ce_ni` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock; all state is clocked by it |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| ce_ni | input | 1 | Active-low chip select, sampled on rising `sclk_i` |
| sio_i | input | 4 | Incoming lane values, sampled on rising `sclk_i` |
| sio_o | output | 4 | Outgoing lane values, updated on falling `sclk_i` |
| sio_oe_o | output | 4 | Per-lane output enable |

## Verification
The bench fills the whole array through serial writes and reads it back through each read command in both modes. Each read uses its own wait-cycle count, so a wrong count shows up as data shifted by a nibble or by several bits. Bursts start near the array end, straddle a 1 KB boundary, and use an address with bit 23 set; a design that mishandled the address would return the wrong bytes. Commands that are illegal or unknown in the current mode are followed by long runs of clocks and must leave every lane undriven and the memory unchanged. Reset sequences with an intervening command check that a stale arm never resets the engine, and mode switches are checked by probing with commands that exist in only one mode.

// File: rtl/sqr_pkg.sv
`timescale 1ns/1ps
package sqr_pkg;
  localparam int WAIT_W = 4;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_ID, K_QEN, K_QEX, K_RSTEN, K_RST
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              addr_quad;
    logic              data_quad;
    logic [WAIT_W-1:0] waits;
  } cmd_info_t;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_WAIT, PH_DATA, PH_HALT} phase_e;
  typedef enum logic [1:0] {PA_NONE, PA_QUAD, PA_SPI, PA_RST} pend_e;
endpackage

// File: rtl/sqr_decode.sv
`timescale 1ns/1ps
module sqr_decode
  import sqr_pkg::*;
#(
  parameter int SPI_FAST_WAIT = 8,
  parameter int QPI_FAST_WAIT = 4,
  parameter int QUAD_RD_WAIT  = 6
) (
  input  logic [7:0] cmd_i,
  input  logic       quad_i,
  output cmd_info_t  info_o
);
  always_comb begin
    info_o           = '0;
    info_o.kind      = K_NONE;
    info_o.addr_quad = quad_i;
    info_o.data_quad = quad_i;
    case (cmd_i)
      8'h03: if (!quad_i) info_o.kind = K_READ;
      8'h0B: begin
        info_o.kind  = K_READ;
        info_o.waits = quad_i ? WAIT_W'(QPI_FAST_WAIT) : WAIT_W'(SPI_FAST_WAIT);
      end
      8'hEB: begin
        info_o.kind      = K_READ;
        info_o.addr_quad = 1'b1;
        info_o.data_quad = 1'b1;
        info_o.waits     = WAIT_W'(QUAD_RD_WAIT);
      end
      8'h02: info_o.kind = K_WRITE;
      8'h38: begin
        info_o.kind      = K_WRITE;
        info_o.addr_quad = 1'b1;
        info_o.data_quad = 1'b1;
      end
      8'h9F: if (!quad_i) info_o.kind = K_ID;
      8'h35: if (!quad_i) info_o.kind = K_QEN;
      8'hF5: if (quad_i)  info_o.kind = K_QEX;
      8'h66: info_o.kind = K_RSTEN;
      8'h99: info_o.kind = K_RST;
      default: info_o.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/sqr_mem.sv
`timescale 1ns/1ps
module sqr_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sqram_frontend.sv
`timescale 1ns/1ps
module sqram_frontend
  import sqr_pkg::*;
#(
  parameter int         DEPTH         = 64,
  parameter logic [7:0] ID_BYTE       = 8'h5D,
  parameter int         SPI_FAST_WAIT = 8,
  parameter int         QPI_FAST_WAIT = 4,
  parameter int         QUAD_RD_WAIT  = 6
) (
  input  logic       sclk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic [3:0] sio_i,
  output logic [3:0] sio_o,
  output logic [3:0] sio_oe_o
);
  localparam int AW     = $clog2(DEPTH);
  localparam int CNT_W  = 5;
  localparam int ADR_SB = 24;          // serial address bits
  localparam int ADR_QU = ADR_SB / 4;  // quad address units

  phase_e          phase_q;
  pend_e           pend_q;
  cmd_info_t       info_q, dec;
  logic            quad_q, armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]      sh_q, sh_nx;
  logic [AW-1:0]   adr_sh_q, adr_nx, ptr_q;
  logic            cur_quad, byte_last, addr_last, wr_en, rd_phase;
  logic [7:0]      mem_rd, rd_byte;
  logic [3:0]      out_q, oe_q;

  always_comb begin
    case (phase_q)
      PH_CMD:  cur_quad = quad_q;
      PH_ADDR: cur_quad = info_q.addr_quad;
      default: cur_quad = info_q.data_quad;
    endcase
  end

  assign sh_nx     = cur_quad ? {sh_q[3:0], sio_i} : {sh_q[6:0], sio_i[0]};
  assign adr_nx    = cur_quad ? AW'({adr_sh_q, sio_i}) : AW'({adr_sh_q, sio_i[0]});
  assign byte_last = cur_quad ? (cnt_q == CNT_W'(1)) : (cnt_q == CNT_W'(7));
  assign addr_last = cur_quad ? (cnt_q == CNT_W'(ADR_QU - 1)) : (cnt_q == CNT_W'(ADR_SB - 1));

  sqr_decode #(
    .SPI_FAST_WAIT(SPI_FAST_WAIT),
    .QPI_FAST_WAIT(QPI_FAST_WAIT),
    .QUAD_RD_WAIT (QUAD_RD_WAIT)
  ) u_dec (
    .cmd_i (sh_nx),
    .quad_i(quad_q),
    .info_o(dec)
  );

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      pend_q   <= PA_NONE;
      info_q   <= '0;
      quad_q   <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      adr_sh_q <= '0;
      ptr_q    <= '0;
    end else if (ce_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      pend_q  <= PA_NONE;
      case (pend_q)
        PA_QUAD: quad_q <= 1'b1;
        PA_SPI:  quad_q <= 1'b0;
        PA_RST: begin
          quad_q  <= 1'b0;
          armed_q <= 1'b0;
        end
        default: ;
      endcase
    end else begin
      case (phase_q)
        PH_CMD: begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (byte_last) begin
            cnt_q   <= '0;
            info_q  <= dec;
            armed_q <= (dec.kind == K_RSTEN);
            phase_q <= PH_HALT;
            case (dec.kind)
              K_READ, K_WRITE, K_ID: phase_q <= PH_ADDR;
              K_QEN: pend_q <= PA_QUAD;
              K_QEX: pend_q <= PA_SPI;
              K_RST: if (armed_q) pend_q <= PA_RST;
              default: ;
            endcase
          end
        end
        PH_ADDR: begin
          adr_sh_q <= adr_nx;
          cnt_q    <= cnt_q + 1'b1;
          if (addr_last) begin
            cnt_q   <= '0;
            ptr_q   <= adr_nx;
            phase_q <= (info_q.waits == '0) ? PH_DATA : PH_WAIT;
          end
        end
        PH_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(info_q.waits) - CNT_W'(1)) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
          end
        end
        PH_DATA: begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (byte_last) begin
            cnt_q <= '0;
            ptr_q <= ptr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en = !ce_ni && (phase_q == PH_DATA) && (info_q.kind == K_WRITE) && byte_last;

  sqr_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i  (sclk_i),
    .we_i   (wr_en),
    .waddr_i(ptr_q),
    .wdata_i(sh_nx),
    .raddr_i(ptr_q),
    .rdata_o(mem_rd)
  );

  assign rd_byte  = (info_q.kind == K_ID) ? ID_BYTE : mem_rd;
  assign rd_phase = !ce_ni && (phase_q == PH_DATA) &&
                    (info_q.kind == K_READ || info_q.kind == K_ID);

  // launch on falling edge so the host samples a settled value on the rising edge
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= '0;
    end else if (!rd_phase) begin
      out_q <= '0;
      oe_q  <= '0;
    end else if (info_q.data_quad) begin
      out_q <= cnt_q[0] ? rd_byte[3:0] : rd_byte[7:4];
      oe_q  <= 4'hF;
    end else begin
      out_q <= {2'b00, rd_byte[3'd7 - cnt_q[2:0]], 1'b0};
      oe_q  <= 4'b0010;
    end
  end

  assign sio_o    = out_q;
  assign sio_oe_o = ce_ni ? 4'h0 : oe_q;

  AST_QEN_FROM_SPI: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (pend_q == PA_QUAD) |-> !quad_q); // R2
  AST_QEX_FROM_QUAD: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (pend_q == PA_SPI) |-> quad_q); // R2
  AST_MODE_HELD: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !ce_ni |=> $stable(quad_q)); // R2
  AST_RST_TO_SPI: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (ce_ni && pend_q == PA_RST) |=> !quad_q && !armed_q); // R7
  AST_BURST_STEP: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!ce_ni && phase_q == PH_DATA && byte_last) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R9
  AST_OE_LANES: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (oe_q == 4'h0 || oe_q == 4'b0010 || oe_q == 4'hF)); // R3
endmodule

// File: tb/sqram_frontend_tb.sv
`timescale 1ns/1ps
module sqram_frontend_tb;
  localparam int DEPTH = 64;
  localparam logic [7:0] IDV = 8'h5D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic [3:0] din = 4'h0;
  logic [3:0] sio_o, sio_oe;

  always #4 clk = ~clk;

  sqram_frontend #(.DEPTH(DEPTH), .ID_BYTE(IDV)) u_dut (
    .sclk_i  (clk),
    .rst_ni  (rst_n),
    .ce_ni   (ce_n),
    .sio_i   (din),
    .sio_o   (sio_o),
    .sio_oe_o(sio_oe)
  );

  int total = 0, bad = 0, hold_err = 0;
  logic cs = 1'b1;
  logic oe_bad;
  logic [3:0] seen_oe;
  logic [7:0] model [DEPTH];
  logic [7:0] rbuf  [DEPTH];
  logic [7:0] wbuf  [DEPTH];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    @(negedge clk);
    #1;
    ce_n = cs;
    din  = d;
    #2;
    q  = sio_o;
    oe = sio_oe;
    seen_oe |= sio_oe;
    @(posedge clk);
    #1;
    if (sio_o !== q) hold_err++;
  endtask

  task automatic put(input logic [3:0] d);
    logic [3:0] a, b;
    cyc(d, a, b);
  endtask

  task automatic end_tx();
    cs = 1'b1;
    put(4'h0);
    put(4'h0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit q);
    if (q) begin
      put(b[7:4]);
      put(b[3:0]);
    end else begin
      for (int i = 7; i >= 0; i--) put({3'b000, b[i]});
    end
  endtask

  task automatic send_addr(input logic [23:0] a, input bit q);
    if (q) begin
      for (int i = 5; i >= 0; i--) put(a[i*4 +: 4]);
    end else begin
      for (int i = 23; i >= 0; i--) put({3'b000, a[i]});
    end
  endtask

  task automatic rd(input logic [7:0] cmd, input bit cq, input bit aq, input bit dq,
                    input int waits, input logic [23:0] a, input int n);
    logic [3:0] q, oe;
    logic [7:0] b;
    oe_bad = 1'b0;
    cs = 1'b0;
    send_byte(cmd, cq);
    send_addr(a, aq);
    for (int w = 0; w < waits; w++) put(4'h0);
    for (int k = 0; k < n; k++) begin
      b = 8'h00;
      if (dq) begin
        for (int u = 0; u < 2; u++) begin
          cyc(4'h0, q, oe);
          if (oe !== 4'hF) oe_bad = 1'b1;
          b = {b[3:0], q};
        end
      end else begin
        for (int u = 0; u < 8; u++) begin
          cyc(4'h0, q, oe);
          if (oe !== 4'b0010) oe_bad = 1'b1;
          b = {b[6:0], q[1]};
        end
      end
      rbuf[k] = b;
    end
    end_tx();
  endtask

  task automatic wr(input logic [7:0] cmd, input bit cq, input bit aq, input bit dq,
                    input logic [23:0] a, input int n);
    cs = 1'b0;
    send_byte(cmd, cq);
    send_addr(a, aq);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], dq);
      model[(int'(a) + k) % DEPTH] = wbuf[k];
    end
    end_tx();
  endtask

  task automatic chk_rd(input string tag, input int base, input int n);
    for (int k = 0; k < n; k++)
      chk(rbuf[k] === model[(base + k) % DEPTH], tag, rbuf[k], model[(base + k) % DEPTH]);
    chk(!oe_bad, {tag, " lanes"}, oe_bad, 0);
  endtask

  task automatic chk_id(input string tag);
    rd(8'h9F, 0, 0, 0, 0, 24'h00007B, 3);
    for (int k = 0; k < 3; k++) chk(rbuf[k] === IDV, tag, rbuf[k], IDV);
  endtask

  task automatic silent(input logic [7:0] cmd, input bit q, input string tag);
    seen_oe = 4'h0;
    cs = 1'b0;
    send_byte(cmd, q);
    for (int i = 0; i < 32; i++) put(4'hF);
    end_tx();
    chk(seen_oe == 4'h0, tag, seen_oe, 0);
  endtask

  initial begin
    #1200000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seen_oe = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    put(4'h0);
    chk(sio_oe == 4'h0, "R1 oe after reset", sio_oe, 0);
    chk_id("R1 SPI mode after reset");

    // R3: serial write of the whole array, then slow serial read
    for (int i = 0; i < DEPTH; i++) wbuf[i] = 8'((i * 37 + 11) & 8'hFF);
    wr(8'h02, 0, 0, 0, 24'h000000, DEPTH);
    rd(8'h03, 0, 0, 0, 0, 24'h000000, DEPTH);
    chk_rd("R3 slow read", 0, DEPTH);

    // R3 R9: fast read with 8 waits, wrapping past array end
    rd(8'h0B, 0, 0, 0, 8, 24'd60, 8);
    chk_rd("R3 R9 fast read wrap", 60, 8);

    // R9: bit 23 ignored, burst across a 1 KB boundary
    rd(8'h03, 0, 0, 0, 0, 24'h80000A, 4);
    chk_rd("R9 top bit ignored", 10, 4);
    rd(8'h03, 0, 0, 0, 0, 24'h0003FE, 4);
    chk_rd("R9 page crossing", 'h3FE, 4);

    // R4: quad write and quad read from SPI mode
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    wr(8'h38, 0, 1, 1, 24'd20, 3);
    rd(8'hEB, 0, 1, 1, 6, 24'd19, 5);
    chk_rd("R4 SPI quad read", 19, 5);

    // R8
    chk_id("R8 ID read");

    // R10: unknown command, memory untouched
    silent(8'hA5, 0, "R10 unknown no drive");
    rd(8'h03, 0, 0, 0, 0, 24'd0, 4);
    chk_rd("R10 memory intact", 0, 4);

    // R2: 0xF5 in SPI ignored
    cs = 1'b0; send_byte(8'hF5, 0); end_tx();
    chk_id("R2 F5 ignored in SPI");

    // R2: enter quad mode
    cs = 1'b0; send_byte(8'h35, 0); end_tx();
    rd(8'h0B, 1, 1, 1, 4, 24'd0, 6);
    chk_rd("R2 R5 quad fast read", 0, 6);

    // R6: rejected in quad mode
    silent(8'h9F, 1, "R6 9F rejected");
    silent(8'h03, 1, "R6 03 rejected");

    // R5: quad writes with both codes, quad reads
    wbuf[0] = 8'h5A; wbuf[1] = 8'h3C;
    wr(8'h02, 1, 1, 1, 24'd40, 2);
    wbuf[0] = 8'hE7; wbuf[1] = 8'h18;
    wr(8'h38, 1, 1, 1, 24'd42, 2);
    rd(8'hEB, 1, 1, 1, 6, 24'd39, 5);
    chk_rd("R5 quad EB read", 39, 5);
    rd(8'h0B, 1, 1, 1, 4, 24'd41, 3);
    chk_rd("R5 quad 0B read", 41, 3);

    // R2: 0x35 ignored in quad mode
    cs = 1'b0; send_byte(8'h35, 1); end_tx();
    rd(8'h0B, 1, 1, 1, 4, 24'd20, 3);
    chk_rd("R2 35 ignored in quad", 20, 3);

    // R7: arm broken by another command
    cs = 1'b0; send_byte(8'h66, 1); end_tx();
    cs = 1'b0; send_byte(8'h00, 1); end_tx();
    cs = 1'b0; send_byte(8'h99, 1); end_tx();
    rd(8'h0B, 1, 1, 1, 4, 24'd0, 2);
    chk_rd("R7 broken arm no reset", 0, 2);

    // R7: proper reset sequence back to SPI
    cs = 1'b0; send_byte(8'h66, 1); end_tx();
    cs = 1'b0; send_byte(8'h99, 1); end_tx();
    chk_id("R7 reset to SPI");

    // R2: quad then explicit exit
    cs = 1'b0; send_byte(8'h35, 0); end_tx();
    cs = 1'b0; send_byte(8'hF5, 1); end_tx();
    chk_id("R2 F5 exit to SPI");

    // R11
    chk(sio_oe == 4'h0, "R11 oe off when deselected", sio_oe, 0);
    chk(hold_err == 0, "R11 output held over rising edge", hold_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule